// File: doc/BRIEF.md
# ECC-Driven DIMM Half Selector

This block runs after a memory error has been traced to one chip-select. A chip-select can drive one DIMM or a pair of DIMMs that share a data word. The block reports which DIMM of the pair holds the fault. Its inputs are two DIMM-present flags, the error address, the ECC scheme in force, a correctable flag and a decoded symbol descriptor. The descriptor carries a data or check flag and the index of the symbol's highest bit.

The rules depend on the ECC scheme. In 64/8 ECC mode each half of the word has its own check bits, so even an uncorrectable error stays within one half. The block therefore picks a half from one address bit. In symbol-based (ChipKill) mode, a correctable error names a symbol, and the bit range of that symbol shows which half it lies in. An uncorrectable symbol-mode error cannot be placed, so both DIMMs are reported.

A request is one cycle with `req_valid` high. The answer appears on the registered outputs in the next cycle.

Top module: `dimm_half_sel`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first request, `rsp_valid`, `dimm_sel`, `no_dimm_err` and `synd_err` are all 0.
- R2: A request sampled at a rising edge produces its result after that same edge, with `rsp_valid`=1. A cycle without a request produces all outputs 0 after the next edge. Back-to-back requests each give their own result.
- R3: When neither DIMM-present flag is set, the result is `no_dimm_err`=1 and `dimm_sel`=2'b00.
- R4: When exactly one DIMM-present flag is set (either one), `dimm_sel`=2'b01 (lower). This holds for every mode, address and descriptor, and `synd_err` stays 0.
- R5: With both DIMMs present and `ecc_mode`=0 (64/8), error address bit 3 set gives 2'b10 (upper) and bit 3 clear gives 2'b01 (lower). The correctable flag and the descriptor have no effect.
- R6: With both DIMMs present, `ecc_mode`=1 and `correctable`=1, a data symbol (`sym_is_data`=1) whose `sym_hi_bit` is 63 or less gives 2'b01, and a larger index gives 2'b10. When `sym_is_data` is set, it takes precedence over `sym_is_check`.
- R7: In the same case with `sym_is_check`=1 and `sym_is_data`=0, a `sym_hi_bit` of 7 or less gives 2'b01, and a larger index gives 2'b10. Address bit 3 has no effect in symbol mode.
- R8: With both DIMMs present, `ecc_mode`=1 and `correctable`=0, the result is 2'b11 (both). The descriptor is ignored and `synd_err` stays 0.
- R9: With both DIMMs present, `ecc_mode`=1 and `correctable`=1, a descriptor with neither flag set gives `synd_err`=1 and `dimm_sel`=2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| lo_present | input | 1 | Lower DIMM populated on this chip-select |
| hi_present | input | 1 | Upper DIMM populated on this chip-select |
| err_addr | input | ADDR_W | Error address |
| ecc_mode | input | 1 | 0 = 64/8 ECC, 1 = symbol (ChipKill) ECC |
| correctable | input | 1 | Error was correctable |
| sym_is_data | input | 1 | Symbol covers data bits |
| sym_is_check | input | 1 | Symbol covers check bits |
| sym_hi_bit | input | SYM_BIT_W | Highest bit index of the symbol |
| rsp_valid | output | 1 | Result valid |
| dimm_sel | output | 2 | 01 lower, 10 upper, 11 both, 00 none |
| no_dimm_err | output | 1 | No DIMM present on chip-select |
| synd_err | output | 1 | Symbol descriptor invalid |

## Verification
The bench targets the threshold edges of the symbol ranges: data index 63 against 64, and check index 7 against 8. An off-by-one comparison would send those symbols to the wrong DIMM. It also sets both descriptor flags at once with values where data and check rules disagree, which exposes a wrong precedence. It places an invalid descriptor under a single DIMM and under an uncorrectable error, where a design that tests the descriptor too early would raise a false `synd_err`. Finally, it varies address bit 3 in symbol mode and the correctable flag in 64/8 mode, which catches a design that mixes up the two selection paths.

// File: rtl/dimm_half_sel_pkg.sv
package dimm_half_sel_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_LO   = 2'b01,
        SEL_HI   = 2'b10,
        SEL_BOTH = 2'b11
    } dsel_e;

    typedef enum logic {
        ECC_SPLIT64 = 1'b0,
        ECC_SYMBOL  = 1'b1
    } ecc_e;

    typedef struct packed {
        logic  vld;
        dsel_e sel;
        logic  no_dimm;
        logic  synd_bad;
    } result_t;

endpackage

// File: rtl/dimm_half_sel_pop.sv
module dimm_half_sel_pop (
    input  logic lo_present,
    input  logic hi_present,
    output logic pop_none,
    output logic pop_single
);
    // Population classification of the chip-select's DIMM slots.
    always_comb begin
        pop_none   = ~(lo_present | hi_present);
        pop_single = lo_present ^ hi_present;
    end
endmodule

// File: rtl/dimm_half_sel_sym.sv
module dimm_half_sel_sym
    import dimm_half_sel_pkg::*;
#(
    parameter int SYM_BIT_W = 7,
    parameter int DATA_TOP  = 63,
    parameter int CHECK_TOP = 7
) (
    input  logic                 is_data,
    input  logic                 is_check,
    input  logic [SYM_BIT_W-1:0] hi_bit,
    output dsel_e                side,
    output logic                 bad
);
    localparam logic [SYM_BIT_W-1:0] DATA_LIM  = SYM_BIT_W'(DATA_TOP);
    localparam logic [SYM_BIT_W-1:0] CHECK_LIM = SYM_BIT_W'(CHECK_TOP);

    // Data flag wins when both are set; neither set is malformed.
    always_comb begin
        bad  = 1'b0;
        side = SEL_HI;
        if (is_data) begin
            side = (hi_bit <= DATA_LIM) ? SEL_LO : SEL_HI;
        end else if (is_check) begin
            side = (hi_bit <= CHECK_LIM) ? SEL_LO : SEL_HI;
        end else begin
            bad  = 1'b1;
            side = SEL_NONE;
        end
    end
endmodule

// File: rtl/dimm_half_sel.sv
module dimm_half_sel
    import dimm_half_sel_pkg::*;
#(
    parameter int ADDR_W    = 40,
    parameter int HALF_BIT  = 3,
    parameter int SYM_BIT_W = 7,
    parameter int DATA_TOP  = 63,
    parameter int CHECK_TOP = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 lo_present,
    input  logic                 hi_present,
    input  logic [ADDR_W-1:0]    err_addr,
    input  logic                 ecc_mode,
    input  logic                 correctable,
    input  logic                 sym_is_data,
    input  logic                 sym_is_check,
    input  logic [SYM_BIT_W-1:0] sym_hi_bit,
    output logic                 rsp_valid,
    output logic [1:0]           dimm_sel,
    output logic                 no_dimm_err,
    output logic                 synd_err
);
    logic    pop_none;
    logic    pop_single;
    dsel_e   sym_side;
    logic    sym_bad;
    result_t res_d;
    result_t res_q;

    dimm_half_sel_pop u_pop (
        .lo_present (lo_present),
        .hi_present (hi_present),
        .pop_none   (pop_none),
        .pop_single (pop_single)
    );

    dimm_half_sel_sym #(
        .SYM_BIT_W (SYM_BIT_W),
        .DATA_TOP  (DATA_TOP),
        .CHECK_TOP (CHECK_TOP)
    ) u_sym (
        .is_data  (sym_is_data),
        .is_check (sym_is_check),
        .hi_bit   (sym_hi_bit),
        .side     (sym_side),
        .bad      (sym_bad)
    );

    always_comb begin
        res_d = '0;
        if (req_valid) begin
            res_d.vld = 1'b1;
            if (pop_none) begin
                res_d.no_dimm = 1'b1;
            end else if (pop_single) begin
                res_d.sel = SEL_LO;
            end else if (ecc_e'(ecc_mode) == ECC_SPLIT64) begin
                res_d.sel = err_addr[HALF_BIT] ? SEL_HI : SEL_LO;
            end else if (!correctable) begin
                res_d.sel = SEL_BOTH;
            end else if (sym_bad) begin
                res_d.synd_bad = 1'b1;
            end else begin
                res_d.sel = sym_side;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign rsp_valid   = res_q.vld;
    assign dimm_sel    = res_q.sel;
    assign no_dimm_err = res_q.no_dimm;
    assign synd_err    = res_q.synd_bad;

endmodule

// File: rtl/dimm_half_sel_checker.sv
module dimm_half_sel_checker #(
    parameter int ADDR_W    = 40,
    parameter int HALF_BIT  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              lo_present,
    input logic              hi_present,
    input logic [ADDR_W-1:0] err_addr,
    input logic              ecc_mode,
    input logic              correctable,
    input logic              rsp_valid,
    input logic [1:0]        dimm_sel,
    input logic              no_dimm_err,
    input logic              synd_err
);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && dimm_sel == 2'b00 && !no_dimm_err && !synd_err));

    p_req_answered_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_empty_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !lo_present && !hi_present) |=> (no_dimm_err && dimm_sel == 2'b00));

    p_single_lower_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (lo_present ^ hi_present)) |=> (dimm_sel == 2'b01 && !synd_err));

    p_split64_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && lo_present && hi_present && !ecc_mode)
        |=> (dimm_sel == ($past(err_addr[HALF_BIT]) ? 2'b10 : 2'b01)));

    p_uncorr_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && lo_present && hi_present && ecc_mode && !correctable)
        |=> (dimm_sel == 2'b11 && !synd_err));

    p_synd_no_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        synd_err |-> (dimm_sel == 2'b00 && rsp_valid && !no_dimm_err));

    p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({no_dimm_err, synd_err}));
endmodule

bind dimm_half_sel dimm_half_sel_checker #(
    .ADDR_W   (ADDR_W),
    .HALF_BIT (HALF_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .lo_present  (lo_present),
    .hi_present  (hi_present),
    .err_addr    (err_addr),
    .ecc_mode    (ecc_mode),
    .correctable (correctable),
    .rsp_valid   (rsp_valid),
    .dimm_sel    (dimm_sel),
    .no_dimm_err (no_dimm_err),
    .synd_err    (synd_err)
);

// File: tb/dimm_half_sel_bench.sv
`timescale 1ns/1ps
module dimm_half_sel_bench;
    localparam int ADDR_W = 40;
    localparam int SYM_W  = 7;

    typedef struct packed {
        logic       lo;
        logic       hi;
        logic       mode;
        logic       corr;
        logic       isd;
        logic       isc;
        logic [6:0] hib;
        logic       a3;
        logic [1:0] xsel;
        logic       xnd;
        logic       xse;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 16;
    // lo hi mode corr isd isc hib a3 | sel nd se | requirement
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,7'd5,  1'b0, 2'b00,1'b1,1'b0, 4'd3}, // R3
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,7'd0,  1'b1, 2'b00,1'b1,1'b0, 4'd3}, // R3
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,7'd0,  1'b1, 2'b01,1'b0,1'b0, 4'd4}, // R4 bad descr ignored
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,7'd0,  1'b1, 2'b01,1'b0,1'b0, 4'd4}, // R4 upper slot only
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,7'd0,  1'b1, 2'b10,1'b0,1'b0, 4'd5}, // R5
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,7'd0,  1'b1, 2'b10,1'b0,1'b0, 4'd5}, // R5 uncorrectable
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,7'd100,1'b0, 2'b01,1'b0,1'b0, 4'd5}, // R5
        '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,7'd63, 1'b1, 2'b01,1'b0,1'b0, 4'd6}, // R6 edge
        '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,7'd64, 1'b0, 2'b10,1'b0,1'b0, 4'd6}, // R6 edge
        '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,7'd7,  1'b1, 2'b01,1'b0,1'b0, 4'd7}, // R7 edge
        '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,7'd8,  1'b0, 2'b10,1'b0,1'b0, 4'd7}, // R7 edge
        '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,7'd0,  1'b0, 2'b11,1'b0,1'b0, 4'd8}, // R8
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,7'd0,  1'b0, 2'b11,1'b0,1'b0, 4'd8}, // R8 bad descr ignored
        '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,7'd3,  1'b0, 2'b00,1'b0,1'b1, 4'd9}, // R9
        '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,7'd10, 1'b0, 2'b01,1'b0,1'b0, 4'd6}, // R6 precedence
        '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,7'd127,1'b0, 2'b10,1'b0,1'b0, 4'd6}  // R6
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              lo_present = 1'b0;
    logic              hi_present = 1'b0;
    logic [ADDR_W-1:0] err_addr = '0;
    logic              ecc_mode = 1'b0;
    logic              correctable = 1'b0;
    logic              sym_is_data = 1'b0;
    logic              sym_is_check = 1'b0;
    logic [SYM_W-1:0]  sym_hi_bit = '0;
    logic              rsp_valid;
    logic [1:0]        dimm_sel;
    logic              no_dimm_err;
    logic              synd_err;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    dimm_half_sel u_dimm_half_sel (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid),
        .lo_present (lo_present), .hi_present (hi_present),
        .err_addr (err_addr), .ecc_mode (ecc_mode),
        .correctable (correctable), .sym_is_data (sym_is_data),
        .sym_is_check (sym_is_check), .sym_hi_bit (sym_hi_bit),
        .rsp_valid (rsp_valid), .dimm_sel (dimm_sel),
        .no_dimm_err (no_dimm_err), .synd_err (synd_err)
    );

    task automatic check(input string tag, input logic xv, input logic [1:0] xs,
                         input logic xn, input logic xe);
        n_chk++;
        if (rsp_valid !== xv || dimm_sel !== xs || no_dimm_err !== xn || synd_err !== xe) begin
            n_fail++;
            $display("FAIL %s: got vld=%b sel=%b nd=%b se=%b, expected vld=%b sel=%b nd=%b se=%b",
                     tag, rsp_valid, dimm_sel, no_dimm_err, synd_err, xv, xs, xn, xe);
        end
    endtask

    task automatic drive(input vec_t v);
        req_valid    = 1'b1;
        lo_present   = v.lo;
        hi_present   = v.hi;
        ecc_mode     = v.mode;
        correctable  = v.corr;
        sym_is_data  = v.isd;
        sym_is_check = v.isc;
        sym_hi_bit   = v.hib;
        err_addr     = 40'h12_3456_7F00 | (ADDR_W'(v.a3) << 3) | 40'h5;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 1'b0, 2'b00, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-reset idle", 1'b0, 2'b00, 1'b0, 1'b0);

        // Table, back to back: result of vector i checked while i+1 is driven (R2)
        drive(VECS[0]);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            check($sformatf("R%0d vec %0d", VECS[i].req, i), 1'b1, VECS[i].xsel,
                  VECS[i].xnd, VECS[i].xse);
            if (i + 1 < NV) drive(VECS[i + 1]);
            else req_valid = 1'b0;
        end

        // R2: idle cycle clears everything
        @(negedge clk);
        check("R2 idle after stream", 1'b0, 2'b00, 1'b0, 1'b0);

        // R7: address bit 3 ignored in symbol mode, check symbol upper
        drive(VECS[10]);
        err_addr = 40'h8;
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 a3 ignored", 1'b1, 2'b10, 1'b0, 1'b0);

        // R1: reset mid-response
        drive(VECS[4]);
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        check("R1 reset clears result", 1'b0, 2'b00, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after re-release", 1'b0, 2'b00, 1'b0, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule